// File: doc/BRIEF.md
# Codec Serial Port with In-Band Control Slot

This block is a serial audio port that exchanges one audio word per frame with an external codec. The codec supplies the bit clock and the frame sync line. All pins are sampled in the system clock domain, and the block finds bit-clock edges by comparing against a delayed copy. The audio word goes out in the slot that starts on the bit clock after the normal frame sync. Its least significant bit is owned by the port and is never taken from the host: it is 0 in a plain frame and 1 when the host has a control word waiting.

When the codec sees that request, it raises the sync line a second time, half a frame (14 bit clocks) after the normal sync. In the slot that follows this secondary sync, the port shifts out the pending control word and shifts in the codec's control word. If no secondary sync comes, the request stays pending and is flagged again in the next audio word.

The host side has four registers with valid/ready handshakes:
- transmit audio
- receive audio
- transmit control
- receive control

A sync pulse at any other bit position is ignored and sets a sticky error flag.

Top module: `codec_sport`

## Requirements
- R1: After reset, `txd_o` is 0, both transmit ready outputs are 1, both receive valid outputs are 0 and `sync_err_o` is 0. The first sync seen after reset is taken as a normal frame sync at any position.
- R2: After a normal sync (sync line high at a rising bit-clock edge), the transmit audio word is sent MSB first. Bit 11 is sent on the next rising edge and bit 0 on the twelfth. When no control word is pending, bit 0 is sent as 0 whatever the host supplied.
- R3: When a transmit control word is pending at the start of the audio slot, bit 0 of the transmitted audio word is 1.
- R4: A sync at the rising edge 14 bit clocks after a normal sync is a secondary sync. The pending control word is sent MSB first in the 12 bit clocks that follow it. `tx_ctl_ready_o` returns to 1 only after the last bit has been sent.
- R5: The 12 bits on `rxd_i` at the rising edges after a normal sync are captured MSB first into `rx_aud_data_o`. `rx_aud_valid_o` is set and stays set until `rx_aud_ready_i` is seen.
- R6: The 12 bits after a secondary sync are captured MSB first into `rx_ctl_data_o`. `rx_ctl_valid_o` is set and held until `rx_ctl_ready_i`. No control capture takes place in a frame without a secondary sync.
- R7: A sync pulse at any position other than frame start (28 bit clocks after the last normal sync) or the half-frame point does not disturb frame timing or data. It sets `sync_err_o`, which stays set until reset.
- R8: If no secondary sync arrives, the control word stays pending. The next frame's audio word again carries bit 0 = 1, and the word is sent at the next secondary sync.
- R9: `txd_o` changes only on falling bit-clock edges.
- R10: If no audio word was written before the slot starts, the port sends zeros in bits 11..1, with bit 0 following R2 and R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Bit clock from the codec |
| fs_i | input | 1 | Frame sync line (normal and secondary) |
| rxd_i | input | 1 | Serial data from the codec |
| txd_o | output | 1 | Serial data to the codec |
| tx_aud_valid_i | input | 1 | Host offers a transmit audio word |
| tx_aud_ready_o | output | 1 | Transmit audio register empty |
| tx_aud_data_i | input | WORD_W | Transmit audio word |
| rx_aud_valid_o | output | 1 | Received audio word available |
| rx_aud_ready_i | input | 1 | Host takes the received audio word |
| rx_aud_data_o | output | WORD_W | Received audio word |
| tx_ctl_valid_i | input | 1 | Host offers a transmit control word |
| tx_ctl_ready_o | output | 1 | No control word pending |
| tx_ctl_data_i | input | WORD_W | Transmit control word |
| rx_ctl_valid_o | output | 1 | Received control word available |
| rx_ctl_ready_i | input | 1 | Host takes the received control word |
| rx_ctl_data_o | output | WORD_W | Received control word |
| sync_err_o | output | 1 | Sticky misplaced-sync flag |

## Verification
Each bit-clock edge is seen one system clock after the pin changes, so every result lands on a known edge:
- A transmitted bit appears one clock after the falling edge. The bench reads it three clocks later, just before it raises the bit clock.
- A received word, and the return of control ready, are due on the clock that registers the last rising or falling edge of the slot.
- The sticky flag is due on the clock that registers the stray rising edge.

The bench drives whole frames of 28 bit clocks and compares only at frame end or at those sample points. A second sample at the end of each high phase shows that transmit data stayed put across the rising edge.

// File: rtl/csp_pkg.sv
package csp_pkg;
  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_AUD  = 2'd1,
    SLOT_CTL  = 2'd2
  } slot_e;
endpackage

// File: rtl/csp_frame_track.sv
module csp_frame_track
  import csp_pkg::*;
#(
  parameter int FRAME_LEN = 28
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sck_i,
  input  logic  fs_i,
  output logic  rise_o,
  output logic  fall_o,
  output slot_e sync_o,
  output logic  err_o
);
  localparam int HALF = FRAME_LEN / 2;
  localparam int PH_W = $clog2(FRAME_LEN);

  logic            sck_q;
  logic [PH_W-1:0] ph_q, ph_n;
  logic            locked_q, locked_n;
  logic            err_q, err_n;

  assign rise_o = sck_i & ~sck_q;
  assign fall_o = ~sck_i & sck_q;

  always_comb begin
    sync_o   = SLOT_NONE;
    ph_n     = ph_q;
    locked_n = locked_q;
    err_n    = err_q;
    if (rise_o) begin
      ph_n = (ph_q == PH_W'(FRAME_LEN - 1)) ? '0 : ph_q + 1'b1;
      if (fs_i) begin
        if (!locked_q || ph_q == PH_W'(FRAME_LEN - 1)) begin
          sync_o   = SLOT_AUD;
          ph_n     = '0;
          locked_n = 1'b1;
        end else if (ph_q == PH_W'(HALF - 1)) begin
          sync_o = SLOT_CTL;
        end else begin
          err_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      ph_q     <= '0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      sck_q    <= sck_i;
      ph_q     <= ph_n;
      locked_q <= locked_n;
      err_q    <= err_n;
    end
  end

  assign err_o = err_q;
endmodule

// File: rtl/csp_tx_lane.sv
module csp_tx_lane
  import csp_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall_i,
  input  slot_e             sync_i,
  input  logic              aud_valid_i,
  output logic              aud_ready_o,
  input  logic [WORD_W-1:0] aud_data_i,
  input  logic              ctl_valid_i,
  output logic              ctl_ready_o,
  input  logic [WORD_W-1:0] ctl_data_i,
  output logic              txd_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic              aud_full_q, aud_full_n;
  logic [WORD_W-1:0] aud_reg_q, aud_reg_n;
  logic              ctl_pend_q, ctl_pend_n;
  logic [WORD_W-1:0] ctl_reg_q, ctl_reg_n;
  slot_e             start_q, start_n;
  logic              act_q, act_n;
  logic              from_reg_q, from_reg_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] sr_q, sr_n;

  always_comb begin
    aud_full_n = aud_full_q;
    aud_reg_n  = aud_reg_q;
    ctl_pend_n = ctl_pend_q;
    ctl_reg_n  = ctl_reg_q;
    start_n    = start_q;
    act_n      = act_q;
    from_reg_n = from_reg_q;
    cnt_n      = cnt_q;
    sr_n       = sr_q;
    if (sync_i != SLOT_NONE) start_n = sync_i;
    if (fall_i) begin
      if (act_q) begin
        if (cnt_q == CNT_W'(WORD_W - 1)) begin
          act_n      = 1'b0;
          from_reg_n = 1'b0;
          if (from_reg_q) ctl_pend_n = 1'b0;
        end else begin
          sr_n  = sr_q << 1;
          cnt_n = cnt_q + 1'b1;
        end
      end
      if (start_q == SLOT_AUD) begin
        sr_n       = aud_full_q ? aud_reg_q : '0;
        sr_n[0]    = ctl_pend_q;
        aud_full_n = 1'b0;
        act_n      = 1'b1;
        from_reg_n = 1'b0;
        cnt_n      = '0;
        start_n    = SLOT_NONE;
      end else if (start_q == SLOT_CTL) begin
        sr_n       = ctl_pend_q ? ctl_reg_q : '0;
        from_reg_n = ctl_pend_q;
        act_n      = 1'b1;
        cnt_n      = '0;
        start_n    = SLOT_NONE;
      end
    end
    if (aud_valid_i && !aud_full_q) begin
      aud_reg_n  = aud_data_i;
      aud_full_n = 1'b1;
    end
    if (ctl_valid_i && !ctl_pend_q) begin
      ctl_reg_n  = ctl_data_i;
      ctl_pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aud_full_q <= 1'b0;
      aud_reg_q  <= '0;
      ctl_pend_q <= 1'b0;
      ctl_reg_q  <= '0;
      start_q    <= SLOT_NONE;
      act_q      <= 1'b0;
      from_reg_q <= 1'b0;
      cnt_q      <= '0;
      sr_q       <= '0;
    end else begin
      aud_full_q <= aud_full_n;
      aud_reg_q  <= aud_reg_n;
      ctl_pend_q <= ctl_pend_n;
      ctl_reg_q  <= ctl_reg_n;
      start_q    <= start_n;
      act_q      <= act_n;
      from_reg_q <= from_reg_n;
      cnt_q      <= cnt_n;
      sr_q       <= sr_n;
    end
  end

  assign aud_ready_o = ~aud_full_q;
  assign ctl_ready_o = ~ctl_pend_q;
  assign txd_o       = act_q & sr_q[WORD_W-1];
endmodule

// File: rtl/csp_rx_lane.sv
module csp_rx_lane
  import csp_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_i,
  input  slot_e             sync_i,
  input  logic              rxd_i,
  output logic              aud_valid_o,
  input  logic              aud_ready_i,
  output logic [WORD_W-1:0] aud_data_o,
  output logic              ctl_valid_o,
  input  logic              ctl_ready_i,
  output logic [WORD_W-1:0] ctl_data_o
);
  localparam int CNT_W = $clog2(WORD_W);

  logic              act_q, act_n;
  slot_e             kind_q, kind_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [WORD_W-1:0] sr_q, sr_n;
  logic              av_q, av_n, cv_q, cv_n;
  logic [WORD_W-1:0] ad_q, ad_n, cd_q, cd_n;
  logic [WORD_W-1:0] word;

  assign word = {sr_q[WORD_W-2:0], rxd_i};

  always_comb begin
    act_n  = act_q;
    kind_n = kind_q;
    cnt_n  = cnt_q;
    sr_n   = sr_q;
    av_n   = av_q;
    ad_n   = ad_q;
    cv_n   = cv_q;
    cd_n   = cd_q;
    if (aud_ready_i) av_n = 1'b0;
    if (ctl_ready_i) cv_n = 1'b0;
    if (rise_i) begin
      if (act_q) begin
        if (cnt_q == CNT_W'(WORD_W - 1)) begin
          act_n = 1'b0;
          if (kind_q == SLOT_CTL) begin
            cd_n = word;
            cv_n = 1'b1;
          end else begin
            ad_n = word;
            av_n = 1'b1;
          end
        end else begin
          sr_n  = word;
          cnt_n = cnt_q + 1'b1;
        end
      end
      if (sync_i != SLOT_NONE) begin
        act_n  = 1'b1;
        kind_n = sync_i;
        cnt_n  = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      kind_q <= SLOT_NONE;
      cnt_q  <= '0;
      sr_q   <= '0;
      av_q   <= 1'b0;
      ad_q   <= '0;
      cv_q   <= 1'b0;
      cd_q   <= '0;
    end else begin
      act_q  <= act_n;
      kind_q <= kind_n;
      cnt_q  <= cnt_n;
      sr_q   <= sr_n;
      av_q   <= av_n;
      ad_q   <= ad_n;
      cv_q   <= cv_n;
      cd_q   <= cd_n;
    end
  end

  assign aud_valid_o = av_q;
  assign aud_data_o  = ad_q;
  assign ctl_valid_o = cv_q;
  assign ctl_data_o  = cd_q;
endmodule

// File: rtl/codec_sport.sv
module codec_sport
  import csp_pkg::*;
#(
  parameter int WORD_W    = 12,
  parameter int FRAME_LEN = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              fs_i,
  input  logic              rxd_i,
  output logic              txd_o,
  input  logic              tx_aud_valid_i,
  output logic              tx_aud_ready_o,
  input  logic [WORD_W-1:0] tx_aud_data_i,
  output logic              rx_aud_valid_o,
  input  logic              rx_aud_ready_i,
  output logic [WORD_W-1:0] rx_aud_data_o,
  input  logic              tx_ctl_valid_i,
  output logic              tx_ctl_ready_o,
  input  logic [WORD_W-1:0] tx_ctl_data_i,
  output logic              rx_ctl_valid_o,
  input  logic              rx_ctl_ready_i,
  output logic [WORD_W-1:0] rx_ctl_data_o,
  output logic              sync_err_o
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       rise, fall;
  slot_e      sync;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  csp_frame_track #(.FRAME_LEN(FRAME_LEN)) u_track (
    .clk(clk), .rst_n(rst_core_n), .sck_i(sck_i), .fs_i(fs_i),
    .rise_o(rise), .fall_o(fall), .sync_o(sync), .err_o(sync_err_o)
  );

  csp_tx_lane #(.WORD_W(WORD_W)) u_tx (
    .clk(clk), .rst_n(rst_core_n), .fall_i(fall), .sync_i(sync),
    .aud_valid_i(tx_aud_valid_i), .aud_ready_o(tx_aud_ready_o), .aud_data_i(tx_aud_data_i),
    .ctl_valid_i(tx_ctl_valid_i), .ctl_ready_o(tx_ctl_ready_o), .ctl_data_i(tx_ctl_data_i),
    .txd_o(txd_o)
  );

  csp_rx_lane #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst_n(rst_core_n), .rise_i(rise), .sync_i(sync), .rxd_i(rxd_i),
    .aud_valid_o(rx_aud_valid_o), .aud_ready_i(rx_aud_ready_i), .aud_data_o(rx_aud_data_o),
    .ctl_valid_o(rx_ctl_valid_o), .ctl_ready_i(rx_ctl_ready_i), .ctl_data_o(rx_ctl_data_o)
  );
endmodule

// File: rtl/csp_checker.sv
module csp_checker (
  input logic clk,
  input logic rst_n,
  input logic sck_i,
  input logic txd_o,
  input logic tx_aud_ready_o,
  input logic tx_ctl_ready_o,
  input logic rx_aud_valid_o,
  input logic rx_aud_ready_i,
  input logic rx_ctl_valid_o,
  input logic rx_ctl_ready_i,
  input logic sync_err_o
);
  logic sck_d;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck_i;
  end

  p_txd_on_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (txd_o != $past(txd_o)) |-> $past(sck_d && !sck_i));

  p_aud_load_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_aud_ready_o) |-> $past(sck_d && !sck_i));

  p_ctl_release_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ctl_ready_o) |-> $past(sck_d && !sck_i));

  p_rx_aud_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_aud_valid_o && !rx_aud_ready_i) |=> rx_aud_valid_o);

  p_rx_aud_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_aud_valid_o) |-> $past(sck_i && !sck_d));

  p_rx_ctl_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ctl_valid_o && !rx_ctl_ready_i) |=> rx_ctl_valid_o);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err_o |=> sync_err_o);
endmodule

bind codec_sport csp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .txd_o(txd_o),
  .tx_aud_ready_o(tx_aud_ready_o), .tx_ctl_ready_o(tx_ctl_ready_o),
  .rx_aud_valid_o(rx_aud_valid_o), .rx_aud_ready_i(rx_aud_ready_i),
  .rx_ctl_valid_o(rx_ctl_valid_o), .rx_ctl_ready_i(rx_ctl_ready_i),
  .sync_err_o(sync_err_o)
);

// File: tb/sim_codec_sport.sv
module sim_codec_sport;
  localparam int W = 12;

  typedef struct packed {
    logic         pa;
    logic [W-1:0] a;
    logic         pc;
    logic [W-1:0] c;
    logic         sec;
    logic         stray;
    logic [W-1:0] rxa;
    logic [W-1:0] rxc;
    logic [W-1:0] etxa;
    logic [W-1:0] etxc;
    logic         erdy;
    logic         eerr;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{1'b1, 12'hA5D, 1'b0, 12'h000, 1'b0, 1'b0, 12'h3C1, 12'h000, 12'hA5C, 12'h000, 1'b1, 1'b0},
    '{1'b1, 12'h122, 1'b1, 12'h9F6, 1'b1, 1'b0, 12'h0F0, 12'h5AA, 12'h123, 12'h9F6, 1'b1, 1'b0},
    '{1'b1, 12'h0FF, 1'b1, 12'h333, 1'b0, 1'b0, 12'hABC, 12'h000, 12'h0FF, 12'h000, 1'b0, 1'b0},
    '{1'b0, 12'h000, 1'b0, 12'h000, 1'b1, 1'b0, 12'h001, 12'hC3F, 12'h001, 12'h333, 1'b1, 1'b0},
    '{1'b1, 12'h800, 1'b0, 12'h000, 1'b0, 1'b1, 12'hFFF, 12'h000, 12'h800, 12'h000, 1'b1, 1'b1},
    '{1'b1, 12'hFFF, 1'b0, 12'h000, 1'b1, 1'b0, 12'h555, 12'h246, 12'hFFE, 12'h000, 1'b1, 1'b1}
  };

  logic clk, rst_n, sck_i, fs_i, rxd_i, txd_o;
  logic tx_aud_valid_i, tx_aud_ready_o, rx_aud_valid_o, rx_aud_ready_i;
  logic tx_ctl_valid_i, tx_ctl_ready_o, rx_ctl_valid_o, rx_ctl_ready_i, sync_err_o;
  logic [W-1:0] tx_aud_data_i, rx_aud_data_o, tx_ctl_data_i, rx_ctl_data_o;

  int n_chk = 0;
  int n_bad = 0;

  codec_sport u0 (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bit_cycle(input logic fs, input logic rxd, output logic t0, output logic t1);
    @(negedge clk);
    sck_i = 1'b0; fs_i = fs; rxd_i = rxd;
    repeat (3) @(negedge clk);
    t0 = txd_o;
    sck_i = 1'b1;
    repeat (4) @(negedge clk);
    t1 = txd_o;
  endtask

  task automatic push_aud(input logic [W-1:0] d);
    @(negedge clk);
    check("R2 aud ready before push", W'(tx_aud_ready_o), W'(1));
    tx_aud_valid_i = 1'b1; tx_aud_data_i = d;
    @(negedge clk);
    tx_aud_valid_i = 1'b0;
  endtask

  task automatic push_ctl(input logic [W-1:0] d);
    @(negedge clk);
    tx_ctl_valid_i = 1'b1; tx_ctl_data_i = d;
    @(negedge clk);
    tx_ctl_valid_i = 1'b0;
  endtask

  task automatic run_frame(input logic sec, input logic stray, input logic [W-1:0] rxa,
                           input logic [W-1:0] rxc, output logic [W-1:0] txa,
                           output logic [W-1:0] txc);
    logic t0, t1, fs, rd;
    txa = '0; txc = '0;
    for (int k = 0; k < 28; k++) begin
      fs = (k == 0) || (sec && k == 14) || (stray && k == 5);
      rd = 1'b0;
      if (k >= 1 && k <= 12)  rd = rxa[12 - k];
      if (k >= 15 && k <= 26) rd = rxc[26 - k];
      bit_cycle(fs, rd, t0, t1);
      if (k >= 1 && k <= 12)  txa[12 - k] = t0;
      if (k >= 15 && k <= 26) txc[26 - k] = t0;
      if (k == 13) check("R9 txd idle between slots", W'(t0), W'(0));
      if (t1 !== t0) check("R9 txd stable across rising edge", W'(t1), W'(t0));
    end
  endtask

  task automatic check_idle(input string tag);
    @(negedge clk);
    check({tag, " txd"}, W'(txd_o), W'(0));
    check({tag, " tx ready"}, W'({tx_aud_ready_o, tx_ctl_ready_o}), W'(3));
    check({tag, " rx valid"}, W'({rx_aud_valid_o, rx_ctl_valid_o}), W'(0));
    check({tag, " err"}, W'(sync_err_o), W'(0));
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [W-1:0] txa, txc;
    sck_i = 0; fs_i = 0; rxd_i = 0; rst_n = 0;
    tx_aud_valid_i = 0; tx_aud_data_i = '0; rx_aud_ready_i = 0;
    tx_ctl_valid_i = 0; tx_ctl_data_i = '0; rx_ctl_ready_i = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check_idle("R1 reset");

    foreach (VECS[i]) begin
      if (VECS[i].pa) push_aud(VECS[i].a);
      if (VECS[i].pc) push_ctl(VECS[i].c);
      run_frame(VECS[i].sec, VECS[i].stray, VECS[i].rxa, VECS[i].rxc, txa, txc);
      @(negedge clk);
      // R2 R3 R10: audio word with port-owned LSB
      check("R2/R3/R10 tx audio word", txa, VECS[i].etxa);
      // R4 R8: control slot content and pending state
      check("R4/R8 tx control word", txc, VECS[i].etxc);
      check("R4/R8 ctl ready after frame", W'(tx_ctl_ready_o), W'(VECS[i].erdy));
      check("R5 rx audio valid", W'(rx_aud_valid_o), W'(1));
      check("R5 rx audio data", rx_aud_data_o, VECS[i].rxa);
      check("R6 rx control valid", W'(rx_ctl_valid_o), W'(VECS[i].sec));
      if (VECS[i].sec) check("R6 rx control data", rx_ctl_data_o, VECS[i].rxc);
      check("R7 sticky error", W'(sync_err_o), W'(VECS[i].eerr));
      rx_aud_ready_i = 1; rx_ctl_ready_i = 1;
      @(negedge clk);
      rx_aud_ready_i = 0; rx_ctl_ready_i = 0;
      @(negedge clk);
      check("R5/R6 valid cleared by ready", W'({rx_aud_valid_o, rx_ctl_valid_o}), W'(0));
    end

    // R1: reset mid-run clears the sticky flag and frame lock
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check_idle("R1 second reset");

    // R1: after reset the first sync is accepted at any position; R2 unchanged even LSB
    begin
      logic t0, t1;
      for (int k = 0; k < 9; k++) bit_cycle(1'b0, 1'b0, t0, t1);
    end
    push_aud(12'h246);
    run_frame(1'b0, 1'b0, 12'h7E1, 12'h000, txa, txc);
    @(negedge clk);
    check("R1 relock tx audio", txa, 12'h246);
    check("R1 relock rx audio", rx_aud_data_o, 12'h7E1);
    check("R1 relock no error", W'(sync_err_o), W'(0));

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule